// File: doc/BRIEF.md
# Program and Erase Sequencer with Status Byte

This block sits behind the serial command decoder of a flash memory. It holds the 128-byte page staging buffer and the status byte, and it times the automatic page program, sector erase and whole-array erase operations. The decoder opens the buffer at a start byte offset, streams data bytes into it, and then raises one of three start requests. The sequencer accepts the request only when it is idle and no error flag is set. It then stays busy for a parameter-defined number of clock cycles and posts the outcome in the status byte.

The status byte is always readable, including during a busy interval, so the decoder can shift it out at any time. A completion bit reads 1 after power-up and drops to 0 when an operation finishes. Error flags are sticky. A clear-status pulse resets the flags and sets the completion bit again. Two failure-injection inputs decide whether the operation that is finishing reports an error. The decoder or an array model reads the staged bytes through a combinational read port. The sequencer reports the current operation kind and its target page.

Top module: `flash_op_sequencer`

## Requirements
- R1: After reset, status_o is 8'h81, cur_op_o is 0 (idle), cur_page_o is 0, and every buffer byte reads 8'hFF.
- R2: An accepted request drops status bit 0 (ready) for exactly PROG_CYCLES, SECT_CYCLES or CHIP_CYCLES cycles, depending on its kind. op_done_o pulses in the last of those cycles. cur_op_o returns to 0 in the following cycle.
- R3: Status bit 7 goes from 1 to 0 only on the cycle after op_done_o. It goes from 0 to 1 only on the cycle after an accepted request or a clear-status pulse.
- R4: clr_status_i resets only status bit 3 (program error) and bit 4 (erase error), and sets bit 7. Bits 1, 2, 5 and 6 always read 0. If a completion coincides with a clear, the completion's flag and bit-7 update win.
- R5: When a page program completes, bit 3 becomes set if inj_prog_fail_i is high in the op_done_o cycle. When either erase kind completes, bit 4 becomes set if inj_erase_fail_i is high in that cycle. In both cases, bit 0 returns to 1.
- R6: A request made while busy, or while bit 3 or bit 4 is set, raises refused_o in the same cycle. It starts nothing and leaves the status and cur_op_o unchanged. An acceptable request raises accepted_o instead.
- R7: buf_open_i refills all 128 bytes with 8'hFF and sets the write offset to buf_start_i. Each buf_wr_i stores buf_data_i at the offset, then advances it modulo 128 (offset 127 is followed by 0). buf_rd_data_o shows the byte at buf_rd_addr_i in the same cycle.
- R8: While busy, buf_open_i and buf_wr_i are ignored and the buffer contents are unchanged.
- R9: Simultaneous requests resolve as program over sector erase over whole-array erase. cur_op_o encodes 1 = program, 2 = sector erase, 3 = whole-array erase. cur_page_o becomes the page index for a program, sector index times 64 for a sector erase, or 0 for a whole-array erase, and holds that value until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_open_i | input | 1 | Refill buffer with 8'hFF and load the write offset |
| buf_start_i | input | 7 | Starting byte offset within the page |
| buf_wr_i | input | 1 | Store one data byte at the write offset |
| buf_data_i | input | 8 | Data byte to store |
| buf_rd_addr_i | input | 7 | Buffer read offset |
| buf_rd_data_o | output | 8 | Buffer byte at the read offset |
| prog_req_i | input | 1 | Page program request |
| prog_page_i | input | 13 | Page index for program |
| sect_req_i | input | 1 | Sector erase request |
| sect_idx_i | input | 7 | Sector index for erase |
| chip_req_i | input | 1 | Whole-array erase request |
| clr_status_i | input | 1 | Clear-status pulse |
| inj_prog_fail_i | input | 1 | Make the completing program report failure |
| inj_erase_fail_i | input | 1 | Make the completing erase report failure |
| status_o | output | 8 | Status byte |
| accepted_o | output | 1 | Request accepted this cycle |
| refused_o | output | 1 | Request refused this cycle |
| op_done_o | output | 1 | Last busy cycle of an operation |
| cur_op_o | output | 2 | Operation in progress (0 idle) |
| cur_page_o | output | 13 | Target page of the latest accepted operation |

## Verification
The assertions check four properties on every cycle. The busy span counted from a start matches the length chosen for that start. Bit 7 and the error flags move only for the causes permitted. No start is issued while a flag is set or the timer runs. A stored byte lands at its offset, and the buffer stays frozen while busy. Other behaviour is shown only by the bench scenarios, compared against its behavioural model: request priority, the sector-to-page mapping, offset wrap past byte 127, the values of the status byte after each kind of failure, and the completion and clear ordering.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PROG = 2'd1,
    OP_SECT = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  // Priority among simultaneous start requests.
  function automatic op_e pick_op(input logic p, input logic s, input logic c);
    if (p)      return OP_PROG;
    else if (s) return OP_SECT;
    else if (c) return OP_CHIP;
    else        return OP_NONE;
  endfunction

  // Assemble the status byte; unlisted positions are reserved zeros.
  function automatic logic [7:0] pack_status(input logic cmp_n, input logic erase_err,
                                             input logic prog_err, input logic ready);
    return {cmp_n, 2'b00, erase_err, prog_err, 2'b00, ready};
  endfunction

endpackage

// File: rtl/flash_seq_page_buffer.sv
module flash_seq_page_buffer #(
  parameter int PAGE_BYTES = 128,
  parameter int AW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          open_i,
  input  logic [AW-1:0] start_i,
  input  logic          wr_i,
  input  logic [7:0]    data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);

  logic [PAGE_BYTES-1:0][7:0] bytes_q;
  logic [AW-1:0]              ptr_q;
  logic                       open_ok;
  logic                       wr_ok;

  assign open_ok = en_i && open_i;
  assign wr_ok   = en_i && wr_i && !open_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bytes_q <= {PAGE_BYTES{8'hFF}};
      ptr_q   <= '0;
    end else if (open_ok) begin
      bytes_q <= {PAGE_BYTES{8'hFF}};
      ptr_q   <= start_i;
    end else if (wr_ok) begin
      bytes_q[ptr_q] <= data_i;
      ptr_q          <= ptr_q + 1'b1;
    end
  end

  assign rd_data_o = bytes_q[rd_addr_i];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> bytes_q[$past(ptr_q)] == $past(data_i)); // R7

  AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> bytes_q == $past(bytes_q)); // R8

endmodule

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= len_i - 1'b1;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  // Independent span counter for checking the busy length.
  logic [CNT_W-1:0] span_len_q;
  logic [CNT_W-1:0] span_run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      span_len_q <= '0;
      span_run_q <= '0;
    end else if (start_i) begin
      span_len_q <= len_i;
      span_run_q <= '0;
    end else if (busy_q) begin
      span_run_q <= span_run_q + 1'b1;
    end
  end

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> span_run_q == span_len_q - 1'b1); // R2

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q); // R6

endmodule

// File: rtl/flash_seq_status.sv
module flash_seq_status
  import flash_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept_i,
  input  logic       clr_i,
  input  logic       done_i,
  input  logic       set_perr_i,
  input  logic       set_eerr_i,
  input  logic       busy_i,
  output logic [7:0] status_o,
  output logic       err_o
);

  logic cmp_n_q;
  logic perr_q;
  logic eerr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_n_q <= 1'b1;
      perr_q  <= 1'b0;
      eerr_q  <= 1'b0;
    end else begin
      perr_q <= (perr_q && !clr_i) || set_perr_i;
      eerr_q <= (eerr_q && !clr_i) || set_eerr_i;
      if (done_i)                cmp_n_q <= 1'b0;
      else if (accept_i || clr_i) cmp_n_q <= 1'b1;
    end
  end

  assign err_o    = perr_q || eerr_q;
  assign status_o = pack_status(cmp_n_q, eerr_q, perr_q, !busy_i);

  AST_CMP_FALL_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmp_n_q) |-> $past(done_i)); // R3

  AST_CMP_RISE_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_n_q) |-> $past(accept_i || clr_i)); // R3

  AST_PERR_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perr_q) |-> $past(clr_i)); // R4

  AST_EERR_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eerr_q) |-> $past(clr_i)); // R4

  AST_ERR_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !accept_i); // R6

endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
  import flash_seq_pkg::*;
#(
  parameter int PAGE_BYTES  = 128,
  parameter int PAGE_IDX_W  = 13,
  parameter int SECT_IDX_W  = 7,
  parameter int PROG_CYCLES = 500,
  parameter int SECT_CYCLES = 30000,
  parameter int CHIP_CYCLES = 60000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  buf_open_i,
  input  logic [6:0]            buf_start_i,
  input  logic                  buf_wr_i,
  input  logic [7:0]            buf_data_i,
  input  logic [6:0]            buf_rd_addr_i,
  output logic [7:0]            buf_rd_data_o,
  input  logic                  prog_req_i,
  input  logic [PAGE_IDX_W-1:0] prog_page_i,
  input  logic                  sect_req_i,
  input  logic [SECT_IDX_W-1:0] sect_idx_i,
  input  logic                  chip_req_i,
  input  logic                  clr_status_i,
  input  logic                  inj_prog_fail_i,
  input  logic                  inj_erase_fail_i,
  output logic [7:0]            status_o,
  output logic                  accepted_o,
  output logic                  refused_o,
  output logic                  op_done_o,
  output logic [1:0]            cur_op_o,
  output logic [PAGE_IDX_W-1:0] cur_page_o
);

  localparam int BYTE_AW  = $clog2(PAGE_BYTES);
  localparam int PPS_LOG  = PAGE_IDX_W - SECT_IDX_W;
  localparam int MAX_A    = (PROG_CYCLES > SECT_CYCLES) ? PROG_CYCLES : SECT_CYCLES;
  localparam int MAX_LEN  = (MAX_A > CHIP_CYCLES) ? MAX_A : CHIP_CYCLES;
  localparam int CNT_W    = $clog2(MAX_LEN + 1);

  // Named internal events
  logic any_req, busy, err, blocked, accept_evt, done_evt;
  logic set_perr, set_eerr;
  op_e  sel_op, op_q;
  logic [PAGE_IDX_W-1:0] sel_page, page_q;
  logic [CNT_W-1:0]      sel_len;

  assign any_req    = prog_req_i || sect_req_i || chip_req_i;
  assign blocked    = busy || err;
  assign accept_evt = any_req && !blocked;
  assign sel_op     = pick_op(prog_req_i, sect_req_i, chip_req_i);

  always_comb begin
    unique case (sel_op)
      OP_PROG: begin sel_page = prog_page_i;                  sel_len = CNT_W'(PROG_CYCLES); end
      OP_SECT: begin sel_page = {sect_idx_i, {PPS_LOG{1'b0}}}; sel_len = CNT_W'(SECT_CYCLES); end
      OP_CHIP: begin sel_page = '0;                           sel_len = CNT_W'(CHIP_CYCLES); end
      default: begin sel_page = '0;                           sel_len = CNT_W'(1); end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      page_q <= '0;
    end else if (accept_evt) begin
      op_q   <= sel_op;
      page_q <= sel_page;
    end else if (done_evt) begin
      op_q   <= OP_NONE;
    end
  end

  assign set_perr = done_evt && (op_q == OP_PROG) && inj_prog_fail_i;
  assign set_eerr = done_evt && (op_q != OP_PROG) && inj_erase_fail_i;

  flash_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (accept_evt),
    .len_i   (sel_len),
    .busy_o  (busy),
    .done_o  (done_evt)
  );

  flash_seq_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept_evt),
    .clr_i      (clr_status_i),
    .done_i     (done_evt),
    .set_perr_i (set_perr),
    .set_eerr_i (set_eerr),
    .busy_i     (busy),
    .status_o   (status_o),
    .err_o      (err)
  );

  flash_seq_page_buffer #(.PAGE_BYTES(PAGE_BYTES), .AW(BYTE_AW)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (!busy),
    .open_i    (buf_open_i),
    .start_i   (buf_start_i[BYTE_AW-1:0]),
    .wr_i      (buf_wr_i),
    .data_i    (buf_data_i),
    .rd_addr_i (buf_rd_addr_i[BYTE_AW-1:0]),
    .rd_data_o (buf_rd_data_o)
  );

  assign accepted_o = accept_evt;
  assign refused_o  = any_req && blocked;
  assign op_done_o  = done_evt;
  assign cur_op_o   = op_q;
  assign cur_page_o = page_q;

  AST_DONE_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_done_o |=> cur_op_o == OP_NONE); // R2

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accepted_o |=> !status_o[0]); // R2

  AST_REFUSE_KEEPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (refused_o && !op_done_o) |=> $stable(cur_op_o)); // R6

endmodule

// File: tb/flash_op_sequencer_tb.sv
module flash_op_sequencer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int T_PROG = 5;
  localparam int T_SECT = 9;
  localparam int T_CHIP = 13;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        buf_open_i, buf_wr_i;
  logic [6:0]  buf_start_i, buf_rd_addr_i;
  logic [7:0]  buf_data_i, buf_rd_data_o;
  logic        prog_req_i, sect_req_i, chip_req_i, clr_status_i;
  logic [12:0] prog_page_i, cur_page_o;
  logic [6:0]  sect_idx_i;
  logic        inj_prog_fail_i, inj_erase_fail_i;
  logic [7:0]  status_o;
  logic        accepted_o, refused_o, op_done_o;
  logic [1:0]  cur_op_o;

  flash_op_sequencer #(.PROG_CYCLES(T_PROG), .SECT_CYCLES(T_SECT), .CHIP_CYCLES(T_CHIP)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .buf_open_i(buf_open_i), .buf_start_i(buf_start_i), .buf_wr_i(buf_wr_i),
    .buf_data_i(buf_data_i), .buf_rd_addr_i(buf_rd_addr_i), .buf_rd_data_o(buf_rd_data_o),
    .prog_req_i(prog_req_i), .prog_page_i(prog_page_i), .sect_req_i(sect_req_i),
    .sect_idx_i(sect_idx_i), .chip_req_i(chip_req_i), .clr_status_i(clr_status_i),
    .inj_prog_fail_i(inj_prog_fail_i), .inj_erase_fail_i(inj_erase_fail_i),
    .status_o(status_o), .accepted_o(accepted_o), .refused_o(refused_o),
    .op_done_o(op_done_o), .cur_op_o(cur_op_o), .cur_page_o(cur_page_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req  = "R1";
  bit    finished = 0;

  // Behavioural reference model
  int m_rem = 0;
  int m_op = 0;
  int m_page = 0;
  bit m_cmp_n = 1, m_perr = 0, m_eerr = 0;
  int m_ptr = 0;
  int m_buf[128];

  task automatic chk(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    buf_open_i = 0; buf_wr_i = 0; prog_req_i = 0; sect_req_i = 0;
    chip_req_i = 0; clr_status_i = 0;
  endtask

  // Compare outputs before the edge, then advance the model with the same inputs.
  task automatic tick();
    bit busy, any, blk, acc, done;
    int sel;
    #1;
    busy = (m_rem > 0);
    any  = prog_req_i || sect_req_i || chip_req_i;
    blk  = busy || m_perr || m_eerr;
    acc  = any && !blk;
    done = (m_rem == 1);
    chk("status", status_o, (int'(m_cmp_n) << 7) | (int'(m_eerr) << 4) | (int'(m_perr) << 3) | int'(!busy));
    chk("accepted", accepted_o, acc);
    chk("refused", refused_o, any && blk);
    chk("op_done", op_done_o, done);
    chk("cur_op", cur_op_o, m_op);
    chk("cur_page", cur_page_o, m_page);
    chk("rd_data", buf_rd_data_o, m_buf[buf_rd_addr_i]);
    @(posedge clk);
    if (!busy) begin
      if (buf_open_i) begin
        foreach (m_buf[i]) m_buf[i] = 'hFF;
        m_ptr = buf_start_i;
      end else if (buf_wr_i) begin
        m_buf[m_ptr] = buf_data_i;
        m_ptr = (m_ptr + 1) % 128;
      end
    end
    if (clr_status_i) begin m_perr = 0; m_eerr = 0; end
    if (done) begin
      if (m_op == 1) m_perr = m_perr | inj_prog_fail_i;
      else           m_eerr = m_eerr | inj_erase_fail_i;
    end
    if (done) m_cmp_n = 0;
    else if (acc || clr_status_i) m_cmp_n = 1;
    sel = prog_req_i ? 1 : (sect_req_i ? 2 : 3);
    if (acc) begin
      m_rem  = (sel == 1) ? T_PROG : ((sel == 2) ? T_SECT : T_CHIP);
      m_op   = sel;
      m_page = (sel == 1) ? int'(prog_page_i) : ((sel == 2) ? int'(sect_idx_i) * 64 : 0);
    end else if (busy) begin
      m_rem--;
      if (done) m_op = 0;
    end
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (m_rem > 0) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    foreach (m_buf[i]) m_buf[i] = 'hFF;
    idle_inputs();
    buf_start_i = 0; buf_data_i = 0; buf_rd_addr_i = 0; prog_page_i = 0; sect_idx_i = 0;
    inj_prog_fail_i = 0; inj_erase_fail_i = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    cur_req = "R1";
    tick();
    chk("reset status", status_o, 'h81);
    buf_rd_addr_i = 127; tick();
    chk("reset byte 127", buf_rd_data_o, 'hFF);

    // R7: load with wrap past offset 127
    cur_req = "R7";
    buf_open_i = 1; buf_start_i = 125; tick(); buf_open_i = 0;
    for (int k = 0; k < 5; k++) begin
      buf_wr_i = 1; buf_data_i = 8'hA0 + 8'(k); tick();
    end
    buf_wr_i = 0;
    for (int a = 0; a < 128; a++) begin buf_rd_addr_i = 7'(a); tick(); end
    buf_rd_addr_i = 0; tick();
    chk("wrapped byte at 0", buf_rd_data_o, 'hA3);
    buf_rd_addr_i = 127; tick();
    chk("byte at 127", buf_rd_data_o, 'hA2);

    // R2 R3 R8: program, writes ignored while busy
    cur_req = "R2";
    prog_req_i = 1; prog_page_i = 13'h1ABC; tick(); prog_req_i = 0;
    chk("busy status", status_o, 'h80);
    cur_req = "R8";
    buf_open_i = 1; tick(); buf_open_i = 0;
    buf_wr_i = 1; buf_data_i = 8'h55; buf_rd_addr_i = 2; tick(); buf_wr_i = 0;
    cur_req = "R6";
    sect_req_i = 1; sect_idx_i = 3; tick(); sect_req_i = 0;
    cur_req = "R2";
    wait_idle();
    chk("program done status", status_o, 'h01);
    cur_req = "R3";
    tick();
    chk("bit7 stays low", status_o[7], 0);
    cur_req = "R8";
    buf_rd_addr_i = 2; tick();
    chk("byte 2 untouched", buf_rd_data_o, 'hFF);

    // R5 R9: sector erase with injected failure
    cur_req = "R9";
    sect_req_i = 1; sect_idx_i = 5; tick(); sect_req_i = 0;
    chk("sector page", cur_page_o, 320);
    cur_req = "R5";
    inj_erase_fail_i = 1;
    wait_idle();
    inj_erase_fail_i = 0;
    chk("erase error status", status_o, 'h11);

    // R6: refused while flag set
    cur_req = "R6";
    prog_req_i = 1; #1; chk("refused with flag", refused_o, 1); tick(); prog_req_i = 0;
    chk("no op started", cur_op_o, 0);

    // R4: clear
    cur_req = "R4";
    clr_status_i = 1; tick(); clr_status_i = 0;
    chk("after clear", status_o, 'h81);

    // R5: program failure, then clear while an erase runs
    cur_req = "R5";
    prog_req_i = 1; prog_page_i = 13'h0007; tick(); prog_req_i = 0;
    inj_prog_fail_i = 1; wait_idle(); inj_prog_fail_i = 0;
    chk("program error status", status_o, 'h09);
    cur_req = "R4";
    clr_status_i = 1; tick(); clr_status_i = 0;
    chk("clear program flag", status_o, 'h81);
    cur_req = "R9";
    chip_req_i = 1; tick(); chip_req_i = 0;
    chk("chip op", cur_op_o, 3);
    cur_req = "R4";
    repeat (3) tick();
    clr_status_i = 1; tick(); clr_status_i = 0;
    wait_idle();
    chk("chip done status", status_o, 'h01);

    // R4: completion coinciding with clear, completion wins
    cur_req = "R4";
    sect_req_i = 1; sect_idx_i = 1; tick(); sect_req_i = 0;
    while (m_rem > 1) tick();
    inj_erase_fail_i = 1; clr_status_i = 1; tick();
    clr_status_i = 0; inj_erase_fail_i = 0;
    chk("done beats clear", status_o, 'h11);
    clr_status_i = 1; tick(); clr_status_i = 0;

    // R9: priority
    cur_req = "R9";
    sect_req_i = 1; chip_req_i = 1; sect_idx_i = 2; tick(); sect_req_i = 0; chip_req_i = 0;
    chk("sector over chip", cur_op_o, 2);
    wait_idle();
    prog_req_i = 1; sect_req_i = 1; chip_req_i = 1; prog_page_i = 13'h0F0F; tick(); idle_inputs();
    chk("program first", cur_op_o, 1);
    chk("program page", cur_page_o, 'h0F0F);
    wait_idle();
    repeat (2) tick();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule